// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block converts clock-timer activity into an interrupt request. Four divider taps (32 Hz, 8 Hz, 2 Hz and 1 Hz) and a single-cycle seconds-overflow pulse come in from the timer. A high-to-low transition on a tap, or an overflow pulse, sets a sticky flag for that source. Software reads the flags and clears them through a small register port. Each source also has an enable bit.

When at least one flag is set and its enable is also set, the block raises its request. The request carries a 2-bit level that software programs. Level 0 acts as a global mask. Flags set even when their source is disabled, so software can poll them without taking interrupts. Arbitration against other interrupt sources happens outside this block.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, all flags, all enables and the level register are 0, `irq_req_o` is 0 and `irq_level_o` is 0.
- R2: Flag bit positions are: bit0 = 32 Hz tap, bit1 = 8 Hz tap, bit2 = 2 Hz tap, bit3 = 1 Hz tap. A tap that was sampled high on one clock edge and is low on the next sets its flag at that next edge. A rising edge sets nothing.
- R3: Flag bit4 is set at any clock edge where `ovf_i` is 1.
- R4: A flag stays set until a write to address 1 has a 1 in that bit. Bits written as 0 are left unchanged.
- R5: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: Flags set whatever their enable bits hold. Reading address 1 returns the five flags in bits [4:0].
- R7: `irq_req_o` is 1 exactly when some flag and its enable (address 0, same bit positions) are both 1 and the level register is non-zero. It follows the registers without delay.
- R8: A level register value of 0 holds `irq_req_o` at 0 regardless of the flags.
- R9: `irq_level_o` equals the level register (address 2, bits [1:0]) while `irq_req_o` is 1, and is 0 otherwise.
- R10: Addresses 0 and 2 read back what was last written, with unused upper bits reading 0. Address 3 reads 0, and writes to it have no effect. Reads are combinational from `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_i | input | NUM_TAPS (4) | Divider taps, bit0 = 32 Hz through bit3 = 1 Hz |
| ovf_i | input | 1 | Seconds-counter overflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 enables, 1 flag clear, 2 level |
| wr_data_i | input | NUM_TAPS+1 (5) | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | NUM_TAPS+1 (5) | Read data |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 2 | Level attached to the request |

## Verification
The risky collision in this block is a flag being set and cleared in the same cycle. The bench provokes it twice: it drops a tap low, and separately pulses the overflow input, in the same cycle as a write-one-to-clear on that bit. It then judges the result by reading the flag register, which must still show the bit set. It also clears a flag while the request is active, and checks that the request and its level fall together.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_FLAGS  = 2'd1,
    RA_LEVEL  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  localparam int LEVEL_W = 2;
endpackage

// File: rtl/tmr_irq_edge.sv
module tmr_irq_edge #(
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tap_i,
  output logic [NUM_TAPS-1:0] fall_o
);
  // One sampling stage per tap; a fall is "was high, now low".
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= tap_i[g];
    end
    assign fall_o[g] = prev_q & ~tap_i[g];
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;   // set has priority over clear
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flags_o[g] = f_q;
  end
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NSRC-1:0]    wr_data_i,
  input  logic [1:0]         rd_addr_i,
  input  logic [NSRC-1:0]    flags_i,
  output logic [NSRC-1:0]    rd_data_o,
  output logic [NSRC-1:0]    enable_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic [NSRC-1:0]    clr_o
);
  logic [NSRC-1:0]    enable_q;
  logic [LEVEL_W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      level_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == RA_ENABLE) enable_q <= wr_data_i;
      if (wr_addr_i == RA_LEVEL)  level_q  <= wr_data_i[LEVEL_W-1:0];
    end
  end

  assign clr_o = (wr_en_i && wr_addr_i == RA_FLAGS) ? wr_data_i : '0;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_ENABLE: rd_data_o = enable_q;
      RA_FLAGS:  rd_data_o = flags_i;
      RA_LEVEL:  rd_data_o[LEVEL_W-1:0] = level_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign level_o  = level_q;
endmodule

// File: rtl/tmr_irq_req.sv
module tmr_irq_req
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0]    flags_i,
  input  logic [NSRC-1:0]    enable_i,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               req_o,
  output logic [LEVEL_W-1:0] level_o
);
  logic pending;
  assign pending = |(flags_i & enable_i);
  assign req_o   = pending && (level_i != '0);
  assign level_o = req_o ? level_i : '0;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                ovf_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [NUM_TAPS:0]   wr_data_i,
  input  logic [1:0]          rd_addr_i,
  output logic [NUM_TAPS:0]   rd_data_o,
  output logic                irq_req_o,
  output logic [1:0]          irq_level_o
);
  localparam int NSRC = NUM_TAPS + 1;

  logic [NUM_TAPS-1:0] fall_w;
  logic [NSRC-1:0]     set_w, clr_w, flags_w, enable_w;
  logic [LEVEL_W-1:0]  level_w;

  tmr_irq_edge #(.NUM_TAPS(NUM_TAPS)) edge_i (
    .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .fall_o(fall_w)
  );

  assign set_w = {ovf_i, fall_w};

  tmr_irq_flags #(.NSRC(NSRC)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .flags_o(flags_w)
  );

  tmr_irq_regs #(.NSRC(NSRC)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .flags_i(flags_w),
    .rd_data_o(rd_data_o), .enable_o(enable_w), .level_o(level_w), .clr_o(clr_w)
  );

  tmr_irq_req #(.NSRC(NSRC)) req_i (
    .flags_i(flags_w), .enable_i(enable_w), .level_i(level_w),
    .req_o(irq_req_o), .level_o(irq_level_o)
  );
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int NUM_TAPS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TAPS-1:0] tap_i,
  input logic                ovf_i,
  input logic                wr_en_i,
  input logic [1:0]          wr_addr_i,
  input logic [NUM_TAPS:0]   wr_data_i,
  input logic [NUM_TAPS:0]   flags,
  input logic [NUM_TAPS:0]   enables,
  input logic                irq_req_o,
  input logic [1:0]          irq_level_o
);
  logic [NUM_TAPS-1:0] tap_seen;
  logic                armed;
  logic [NUM_TAPS:0]   clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      tap_seen <= '0;
    end else begin
      armed    <= 1'b1;
      tap_seen <= tap_i;
    end
  end

  assign clr_mask = (wr_en_i && wr_addr_i == 2'd1) ? wr_data_i : '0;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_fall
    a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      armed && tap_seen[g] && !tap_i[g] |=> flags[g]);
  end

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flags[NUM_TAPS]);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~$past(clr_mask) & ~flags) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i && clr_mask[NUM_TAPS] |=> flags[NUM_TAPS]);

  a_r7_req_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((flags & enables) != '0));

  a_r8_req_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_level_o != 2'd0));

  a_r9_idle_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (irq_level_o == 2'd0));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.NUM_TAPS(NUM_TAPS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .ovf_i(ovf_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .flags(flags_w), .enables(enable_w),
  .irq_req_o(irq_req_o), .irq_level_o(irq_level_o)
);

// File: tb/tmr_irq_ctrl_tb_top.sv
module tmr_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tap = '0;
  logic       ovf = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [4:0] rd_data;
  logic       irq_req;
  logic [1:0] irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int         kind;   // 0: rd_data, 1: {irq_req, irq_level}
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tmr_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tap_i(tap), .ovf_i(ovf),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_req_o(irq_req), .irq_level_o(irq_level)
  );

  // Monitor: pops expectations and compares against the live outputs.
  initial begin
    forever begin
      item_t it;
      logic [4:0] act;
      wait (sb_q.size() != 0);
      it  = sb_q.pop_front();
      act = (it.kind == 0) ? rd_data : {2'b00, irq_req, irq_level};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [4:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    sb_q.push_back('{0, e, tag});
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_irq(input logic req, input logic [1:0] lvl, input string tag);
    @(negedge clk);
    #1;
    sb_q.push_back('{1, {2'b00, req, lvl}, tag});
    wait (sb_q.size() == 0);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tap_fall(input int idx);
    @(negedge clk); tap[idx] = 1'b1;
    @(negedge clk); tap[idx] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(2'd0, 5'h00, "R1 enables");
    expect_rd(2'd1, 5'h00, "R1 flags");
    expect_rd(2'd2, 5'h00, "R1 level");
    expect_irq(1'b0, 2'd0, "R1 irq");

    // R2 rising edge alone sets nothing
    @(negedge clk); tap[2] = 1'b1;
    @(negedge clk);
    expect_rd(2'd1, 5'h00, "R2 rising edge no set");
    @(negedge clk); tap[2] = 1'b0;
    @(negedge clk);
    expect_rd(2'd1, 5'h04, "R2 fall 2Hz bit2");
    reg_wr(2'd1, 5'h04);

    // R2/R6 each tap fall sets its own flag, enables all 0
    for (int i = 0; i < 4; i++) tap_fall(i);
    expect_rd(2'd1, 5'h0F, "R6 flags set while disabled (R2)");
    expect_irq(1'b0, 2'd0, "R7 no request while disabled");

    // R4 write-one-to-clear, zeros untouched
    reg_wr(2'd1, 5'h05);
    expect_rd(2'd1, 5'h0A, "R4 partial clear");
    reg_wr(2'd1, 5'h0A);
    expect_rd(2'd1, 5'h00, "R4 full clear");

    // R3 overflow pulse
    @(negedge clk); ovf = 1'b1;
    @(negedge clk); ovf = 1'b0;
    expect_rd(2'd1, 5'h10, "R3 overflow sets bit4");

    // R8 level 0 masks
    reg_wr(2'd0, 5'h10);
    expect_irq(1'b0, 2'd0, "R8 level zero suppresses");
    reg_wr(2'd2, 5'h02);
    expect_irq(1'b1, 2'd2, "R7 request with level 2 (R9)");
    expect_rd(2'd2, 5'h02, "R10 level readback");
    expect_rd(2'd0, 5'h10, "R10 enable readback");

    // R5 set wins: overflow and clear of bit4 in the same cycle
    @(negedge clk);
    ovf = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 5'h10;
    @(negedge clk);
    ovf = 1'b0; wr_en = 1'b0;
    expect_rd(2'd1, 5'h10, "R5 overflow beats clear");

    // R5 set wins: tap fall and clear of bit0 in the same cycle
    @(negedge clk); tap[0] = 1'b1;
    @(negedge clk);
    tap[0] = 1'b0; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 5'h01;
    @(negedge clk);
    wr_en = 1'b0;
    expect_rd(2'd1, 5'h11, "R5 tap fall beats clear");

    // R9 clearing the enabled flag drops request and level
    reg_wr(2'd1, 5'h10);
    expect_irq(1'b0, 2'd0, "R9 level zero when idle");
    expect_rd(2'd1, 5'h01, "R4 other flag kept");

    // R10 address 3 ignored
    reg_wr(2'd3, 5'h1F);
    expect_rd(2'd3, 5'h00, "R10 addr3 reads zero");
    expect_rd(2'd0, 5'h10, "R10 addr3 write no effect on enables");
    expect_rd(2'd2, 5'h02, "R10 addr3 write no effect on level");
    expect_rd(2'd1, 5'h01, "R10 addr3 write no effect on flags");

    // R7/R9 32 Hz source at level 3
    reg_wr(2'd0, 5'h01);
    reg_wr(2'd2, 5'h03);
    expect_irq(1'b1, 2'd3, "R7 32Hz request level 3 (R9)");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule